// File: doc/BRIEF.md
# Cipher Command Queue Front End

This block sits in front of a block-cipher datapath and turns a stream of 32-bit command words, written by software into a single queue port, into checked and fully assembled commands. Words land in a small FIFO. A decoder pulls them out while processing is enabled and looks at the 4-bit opcode in bits 31:28. It collects the extra argument words that key and IV loads carry, then hands each finished command downstream over a valid/ready handshake.

The decoder also polices the stream. It rejects opcodes it does not know, key loads with a reserved length or mode, and crypt commands that name a key slot that was never loaded. A barrier command holds back later commands until the datapath reports idle, and it can raise a flag interrupt. Every cause is a sticky write-one-to-clear bit in a status register, and a matching enable register gates the single interrupt line. Software controls the queue through a control register (start, stop, empty queue, engine reset) and watches it through a FIFO status word.

Register offsets, all on one write port and one combinational read port:

| Offset | Register |
|--------|----------|
| 0x00 | control |
| 0x04 | interrupt status |
| 0x08 | interrupt enable |
| 0x0C | FIFO status |
| 0x10 | command push |

Unmapped offsets read as zero.

Top module: `ccq_top`

## Requirements
- R1: After reset the FIFO status reads 0x0000_0002, interrupt status reads 0, `irq` is low, `dsp_valid` is low and processing is stopped.
- R2: The FIFO status word holds the write pointer in bits 31:24, the read pointer in 23:16, the fill level in 15:8, full in bit 2 and empty in bit 1. A write to control with bit 2 set empties the FIFO and returns both pointers to 0.
- R3: A write to the command push offset while the FIFO is full sets status bit 1, and the word is dropped (the level does not change).
- R4: The status bits (1, 2, 5, 7, 11, 13, 17) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it. The enable register stores only those bits. `irq` is the OR of status AND enable.
- R5: Control bit 0 starts processing and bit 1 stops it; when both are written together, stop wins. While processing is stopped, no word leaves the FIFO.
- R6: Opcodes 0, 3, 4, 7 and 9 to 15 set status bit 2, and the word is discarded without being dispatched.
- R7: A key load has opcode 1, slot in bit 27, source in 26:24, length in 23:22 (0/1/2 = 128/192/256) and mode in 17:16. With source 0 it takes the next 4, 6 or 8 words as arguments; other sources take none. Argument k appears on `dsp_args[32k+31:32k]`, and unused words are zero. If the length or the mode is 3, the load is discarded, no arguments are taken, and invalid bit 7 (slot 0) or bit 13 (slot 1) is set.
- R8: An IV load (opcode 2, IV slot in bits 27:26) takes the next 4 words as arguments. An IV readback (opcode 6) takes none.
- R9: A crypt command (opcode 5, key slot in bit 27, IV slot 26:25, length 24:0) is dispatched only if that key slot has had a key load accepted since the last reset. Otherwise it is discarded and sets empty bit 11 (slot 0) or 17 (slot 1).
- R10: While `dsp_valid` is high and `dsp_ready` is low, the valid signal, the word, the argument count and the arguments hold steady. A command is transferred in the cycle where both are high. `dsp_op` equals `dsp_word[31:28]`.
- R11: A barrier (opcode 8) is never dispatched. It waits until `dp_busy` is low, and it blocks later commands while it waits. When it completes it sets status bit 5 if bit 27 of the barrier word is set.
- R12: A write to control with bit 3 set empties the FIFO, clears all status bits, forgets both loaded key slots, stops processing and returns the decoder to idle. The enable register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | ADDR_W | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| dsp_valid | output | 1 | Command ready for the datapath |
| dsp_ready | input | 1 | Datapath accepts the command |
| dsp_op | output | 4 | Opcode of the command |
| dsp_word | output | 32 | Full command word |
| dsp_nargs | output | 4 | Number of argument words attached |
| dsp_args | output | 256 | Argument words, word k at bits 32k+31:32k |
| dp_busy | input | 1 | Datapath still working on earlier commands |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a FIFO depth of 4, so a handful of pushes fills the queue. That makes the full flag, the overflow drop and pointer wrap-around reachable in a few cycles. With processing stopped, the pointer and level fields can be read at partial fill, at full, and after a clear. With processing running, the eight-word key load passes through this four-entry queue, which shows that argument collection keeps pace with one push every other cycle.

// File: rtl/ccq_pkg.sv
package ccq_pkg;

  // Opcode encodings (bits 31:28 of a command word)
  localparam logic [3:0] OP_SET_KEY = 4'd1;
  localparam logic [3:0] OP_SET_IV  = 4'd2;
  localparam logic [3:0] OP_CRYPT   = 4'd5;
  localparam logic [3:0] OP_GET_IV  = 4'd6;
  localparam logic [3:0] OP_BARRIER = 4'd8;

  // Argument storage sized for the longest key
  localparam int ARG_WORDS = 8;
  localparam int IV_WORDS  = 4;
  localparam int CNT_W     = $clog2(ARG_WORDS + 1);
  localparam int IDX_W     = $clog2(ARG_WORDS);

  // Register byte offsets
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_STAT  = 'h04;
  localparam int OFS_EN    = 'h08;
  localparam int OFS_FIFO  = 'h0C;
  localparam int OFS_PUSH  = 'h10;

  // Control bits
  localparam int CTRL_START = 0;
  localparam int CTRL_STOP  = 1;
  localparam int CTRL_CLR   = 2;
  localparam int CTRL_RST   = 3;

  // Status bit positions
  localparam int ST_OVF      = 1;
  localparam int ST_UNK      = 2;
  localparam int ST_FLAG     = 5;
  localparam int ST_K0_INV   = 7;
  localparam int ST_K0_EMPTY = 11;
  localparam int ST_K1_INV   = 13;
  localparam int ST_K1_EMPTY = 17;
  localparam logic [31:0] ST_MASK = 32'h0002_28A6;

  typedef struct packed {
    logic       unknown;
    logic [1:0] key_empty;
    logic [1:0] key_invalid;
    logic       flag;
  } dec_ev_t;

endpackage

// File: rtl/ccq_fifo.sv
module ccq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [LW-1:0] level_q, level_n;
  logic          do_push, do_pop;

  assign full    = (level_q == LW'(DEPTH));
  assign empty   = (level_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wptr_n  = wptr_q;
    rptr_n  = rptr_q;
    level_n = level_q;
    if (do_push) wptr_n = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + PW'(1);
    if (do_pop)  rptr_n = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + PW'(1);
    unique case ({do_push, do_pop})
      2'b10:   level_n = level_q + LW'(1);
      2'b01:   level_n = level_q - LW'(1);
      default: level_n = level_q;
    endcase
    if (flush) begin
      wptr_n  = '0;
      rptr_n  = '0;
      level_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      wptr_q  <= wptr_n;
      rptr_q  <= rptr_n;
      level_q <= level_n;
    end
  end

  // Storage: written only on an accepted push, no reset needed
  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];
  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign level = level_q;

endmodule

// File: rtl/ccq_decoder.sv
module ccq_decoder
  import ccq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    eng_reset,
  input  logic                    running,
  input  logic                    fifo_empty,
  input  logic [31:0]             head,
  output logic                    pop,
  input  logic                    dsp_ready,
  input  logic                    dp_busy,
  output logic                    dsp_valid,
  output logic [3:0]              dsp_op,
  output logic [31:0]             dsp_word,
  output logic [3:0]              dsp_nargs,
  output logic [ARG_WORDS*32-1:0] dsp_args,
  output dec_ev_t                 ev,
  output logic [1:0]              key_loaded
);

  typedef enum logic [1:0] {S_IDLE, S_ARGS, S_SEND, S_BARR} st_e;

  st_e                          st_q, st_n;
  logic [31:0]                  cmd_q, cmd_n;
  logic [ARG_WORDS-1:0][31:0]   args_q, args_n;
  logic [CNT_W-1:0]             need_q, need_n, cnt_q, cnt_n, cnt_inc;
  logic [1:0]                   ld_q, ld_n;

  logic [3:0] h_op;
  logic       h_slot;
  logic [2:0] h_src;
  logic [1:0] h_len, h_mode;

  assign h_op    = head[31:28];
  assign h_slot  = head[27];
  assign h_src   = head[26:24];
  assign h_len   = head[23:22];
  assign h_mode  = head[17:16];
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    st_n   = st_q;
    cmd_n  = cmd_q;
    args_n = args_q;
    need_n = need_q;
    cnt_n  = cnt_q;
    ld_n   = ld_q;
    pop    = 1'b0;
    ev     = '0;
    unique case (st_q)
      S_IDLE: begin
        if (running && !fifo_empty) begin
          pop    = 1'b1;
          cmd_n  = head;
          args_n = '0;
          need_n = '0;
          cnt_n  = '0;
          case (h_op)
            OP_SET_KEY: begin
              if (h_len == 2'd3 || h_mode == 2'd3) begin
                ev.key_invalid[h_slot] = 1'b1;
              end else if (h_src == 3'd0) begin
                need_n = CNT_W'(3'd4) + CNT_W'({h_len, 1'b0});
                st_n   = S_ARGS;
              end else begin
                st_n = S_SEND;
              end
            end
            OP_SET_IV: begin
              need_n = CNT_W'(IV_WORDS);
              st_n   = S_ARGS;
            end
            OP_CRYPT: begin
              if (ld_q[h_slot]) st_n = S_SEND;
              else              ev.key_empty[h_slot] = 1'b1;
            end
            OP_GET_IV:  st_n = S_SEND;
            OP_BARRIER: st_n = S_BARR;
            default:    ev.unknown = 1'b1;
          endcase
        end
      end
      S_ARGS: begin
        if (running && !fifo_empty) begin
          pop                       = 1'b1;
          args_n[cnt_q[IDX_W-1:0]]  = head;
          cnt_n                     = cnt_inc;
          if (cnt_inc == need_q) st_n = S_SEND;
        end
      end
      S_SEND: begin
        if (dsp_ready) begin
          if (cmd_q[31:28] == OP_SET_KEY) ld_n[cmd_q[27]] = 1'b1;
          st_n = S_IDLE;
        end
      end
      S_BARR: begin
        if (!dp_busy) begin
          ev.flag = cmd_q[27];
          st_n    = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase
    if (eng_reset) begin
      st_n = S_IDLE;
      ld_n = '0;
      pop  = 1'b0;
      ev   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cmd_q  <= '0;
      args_q <= '0;
      need_q <= '0;
      cnt_q  <= '0;
      ld_q   <= '0;
    end else begin
      st_q   <= st_n;
      cmd_q  <= cmd_n;
      args_q <= args_n;
      need_q <= need_n;
      cnt_q  <= cnt_n;
      ld_q   <= ld_n;
    end
  end

  assign dsp_valid  = (st_q == S_SEND);
  assign dsp_word   = cmd_q;
  assign dsp_op     = cmd_q[31:28];
  assign dsp_nargs  = 4'(need_q);
  assign dsp_args   = args_q;
  assign key_loaded = ld_q;

endmodule

// File: rtl/ccq_regs.sv
module ccq_regs
  import ccq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic [31:0]       fifo_stat,
  input  logic              fifo_full,
  input  dec_ev_t           ev,
  output logic              cmd_push,
  output logic              running,
  output logic              clr_fifo,
  output logic              eng_reset,
  output logic [31:0]       status,
  output logic              irq
);

  logic        wr_ctrl, wr_stat, wr_en_reg;
  logic        start, stop;
  logic        run_q, run_n;
  logic [31:0] stat_q, stat_n, en_q, en_n, set_v, clr_v;

  assign wr_ctrl   = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
  assign wr_stat   = wr_en && (wr_addr == ADDR_W'(OFS_STAT));
  assign wr_en_reg = wr_en && (wr_addr == ADDR_W'(OFS_EN));
  assign cmd_push  = wr_en && (wr_addr == ADDR_W'(OFS_PUSH));

  assign start     = wr_ctrl && wr_data[CTRL_START];
  assign stop      = wr_ctrl && wr_data[CTRL_STOP];
  assign clr_fifo  = wr_ctrl && wr_data[CTRL_CLR];
  assign eng_reset = wr_ctrl && wr_data[CTRL_RST];

  always_comb begin
    set_v              = '0;
    set_v[ST_OVF]      = cmd_push && fifo_full;
    set_v[ST_UNK]      = ev.unknown;
    set_v[ST_FLAG]     = ev.flag;
    set_v[ST_K0_INV]   = ev.key_invalid[0];
    set_v[ST_K1_INV]   = ev.key_invalid[1];
    set_v[ST_K0_EMPTY] = ev.key_empty[0];
    set_v[ST_K1_EMPTY] = ev.key_empty[1];
    clr_v              = wr_stat ? wr_data : '0;
    stat_n             = ((stat_q & ~clr_v) | set_v) & ST_MASK;
    if (eng_reset) stat_n = '0;
    en_n = wr_en_reg ? (wr_data & ST_MASK) : en_q;
    run_n = run_q;
    if (start)             run_n = 1'b1;
    if (stop || eng_reset) run_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      run_q  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      en_q   <= en_n;
      run_q  <= run_n;
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_W'(OFS_STAT): rd_data = stat_q;
      ADDR_W'(OFS_EN):   rd_data = en_q;
      ADDR_W'(OFS_FIFO): rd_data = fifo_stat;
      default:           rd_data = '0;
    endcase
  end

  assign running = run_q;
  assign status  = stat_q;
  assign irq     = |(stat_q & en_q);

endmodule

// File: rtl/ccq_top.sv
module ccq_top
  import ccq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr_en,
  input  logic [ADDR_W-1:0]       reg_wr_addr,
  input  logic [31:0]             reg_wr_data,
  input  logic [ADDR_W-1:0]       reg_rd_addr,
  output logic [31:0]             reg_rd_data,
  output logic                    dsp_valid,
  input  logic                    dsp_ready,
  output logic [3:0]              dsp_op,
  output logic [31:0]             dsp_word,
  output logic [3:0]              dsp_nargs,
  output logic [ARG_WORDS*32-1:0] dsp_args,
  input  logic                    dp_busy,
  output logic                    irq
);

  localparam int FIFO_PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int LVL_W   = $clog2(FIFO_DEPTH + 1);

  logic               cmd_push, running, clr_fifo, eng_reset, pop;
  logic               fifo_full, fifo_empty;
  logic [31:0]        head, fifo_stat, irq_status;
  logic [FIFO_PW-1:0] f_wptr, f_rptr;
  logic [LVL_W-1:0]   fifo_level;
  logic [1:0]         key_loaded;
  dec_ev_t            ev;

  ccq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .wr_data   (reg_wr_data),
    .rd_addr   (reg_rd_addr),
    .rd_data   (reg_rd_data),
    .fifo_stat (fifo_stat),
    .fifo_full (fifo_full),
    .ev        (ev),
    .cmd_push  (cmd_push),
    .running   (running),
    .clr_fifo  (clr_fifo),
    .eng_reset (eng_reset),
    .status    (irq_status),
    .irq       (irq)
  );

  ccq_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (clr_fifo || eng_reset),
    .push  (cmd_push),
    .wdata (reg_wr_data),
    .pop   (pop),
    .rdata (head),
    .wptr  (f_wptr),
    .rptr  (f_rptr),
    .level (fifo_level),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  assign fifo_stat = {8'(f_wptr), 8'(f_rptr), 8'(fifo_level), 5'b0, fifo_full, fifo_empty, 1'b0};

  ccq_decoder u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .eng_reset  (eng_reset),
    .running    (running),
    .fifo_empty (fifo_empty),
    .head       (head),
    .pop        (pop),
    .dsp_ready  (dsp_ready),
    .dp_busy    (dp_busy),
    .dsp_valid  (dsp_valid),
    .dsp_op     (dsp_op),
    .dsp_word   (dsp_word),
    .dsp_nargs  (dsp_nargs),
    .dsp_args   (dsp_args),
    .ev         (ev),
    .key_loaded (key_loaded)
  );

endmodule

// File: rtl/ccq_checker.sv
module ccq_checker #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dsp_valid,
  input logic          dsp_ready,
  input logic [3:0]    dsp_op,
  input logic [31:0]   dsp_word,
  input logic [3:0]    dsp_nargs,
  input logic [255:0]  dsp_args,
  input logic          dp_busy,
  input logic          cmd_push,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic [LW-1:0] fifo_level,
  input logic [31:0]   irq_status,
  input logic [1:0]    key_loaded
);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid && !dsp_ready |=> dsp_valid && $stable(dsp_word) && $stable(dsp_nargs) && $stable(dsp_args));

  assert_legal_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> (dsp_op == 4'd1 || dsp_op == 4'd2 || dsp_op == 4'd5 || dsp_op == 4'd6));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push && fifo_full |=> irq_status[1]);

  assert_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level <= LW'(DEPTH)) && !(fifo_full && fifo_empty));

  assert_crypt_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid && dsp_op == 4'd5 |-> key_loaded[dsp_word[27]]);

  assert_flag_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status[5]) |-> $past(!dp_busy));

  assert_key_nargs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid && dsp_op == 4'd1 && dsp_word[26:24] == 3'd0
      |-> dsp_nargs == 4'd4 + {1'b0, dsp_word[23:22], 1'b0});

endmodule

bind ccq_top ccq_checker #(.DEPTH(FIFO_DEPTH), .LW(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dsp_valid  (dsp_valid),
  .dsp_ready  (dsp_ready),
  .dsp_op     (dsp_op),
  .dsp_word   (dsp_word),
  .dsp_nargs  (dsp_nargs),
  .dsp_args   (dsp_args),
  .dp_busy    (dp_busy),
  .cmd_push   (cmd_push),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .fifo_level (fifo_level),
  .irq_status (irq_status),
  .key_loaded (key_loaded)
);

// File: tb/ccq_top_tb.sv
`timescale 1ns/1ps
module ccq_top_tb;

  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_EN = 8'h08, A_FIFO = 8'h0C, A_PUSH = 8'h10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr_en = 1'b0;
  logic [7:0]   reg_wr_addr = '0;
  logic [31:0]  reg_wr_data = '0;
  logic [7:0]   reg_rd_addr = '0;
  logic [31:0]  reg_rd_data;
  logic         dsp_valid, dsp_ready = 1'b1;
  logic [3:0]   dsp_op, dsp_nargs;
  logic [31:0]  dsp_word;
  logic [255:0] dsp_args;
  logic         dp_busy = 1'b0;
  logic         irq;

  int n_checks = 0, n_err = 0, exp_n = 0;
  bit done = 1'b0;

  logic [31:0]  lg_word [64];
  logic [3:0]   lg_op [64];
  logic [3:0]   lg_nargs [64];
  logic [255:0] lg_args [64];
  int           lg_cnt = 0;

  always #4 clk = ~clk;

  ccq_top #(.FIFO_DEPTH(4), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_op(dsp_op), .dsp_word(dsp_word),
    .dsp_nargs(dsp_nargs), .dsp_args(dsp_args), .dp_busy(dp_busy), .irq(irq)
  );

  // Record every transferred command
  always @(posedge clk) begin
    if (rst_n && dsp_valid && dsp_ready && lg_cnt < 64) begin
      lg_word[lg_cnt]  <= dsp_word;
      lg_op[lg_cnt]    <= dsp_op;
      lg_nargs[lg_cnt] <= dsp_nargs;
      lg_args[lg_cnt]  <= dsp_args;
      lg_cnt           <= lg_cnt + 1;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_addr = a;
    #1 d = reg_rd_data;
  endtask

  task automatic chk_reg(input string req, input string what, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, what, d, exp);
  endtask

  task automatic chk_disp(input string req, input int idx, input logic [3:0] op, input logic [31:0] w, input logic [3:0] na);
    check(req, "dispatch op", {28'd0, lg_op[idx]}, {28'd0, op});
    check(req, "dispatch word", lg_word[idx], w);
    check(req, "dispatch nargs", {28'd0, lg_nargs[idx]}, {28'd0, na});
  endtask

  function automatic logic [31:0] arg_of(input int idx, input int k);
    return lg_args[idx][32*k +: 32];
  endfunction

  task automatic t_reset();
    chk_reg("R1", "fifo status", A_FIFO, 32'h0000_0002);
    chk_reg("R1", "irq status", A_STAT, 32'h0);
    check("R1", "irq", {31'd0, irq}, 32'd0);
    check("R1", "dsp_valid", {31'd0, dsp_valid}, 32'd0);
    wr(A_PUSH, 32'h6000_0000);
    idle(4);
    check("R1", "stopped after reset", lg_cnt, 0);
    wr(A_CTRL, 32'h4);
  endtask

  task automatic t_fifo();
    for (int i = 0; i < 3; i++) wr(A_PUSH, 32'h6000_0000);
    chk_reg("R2", "partial fill", A_FIFO, 32'h0300_0300);
    wr(A_PUSH, 32'h6000_0000);
    chk_reg("R2", "full wrap", A_FIFO, 32'h0000_0404);
    wr(A_PUSH, 32'h6000_0000);
    chk_reg("R3", "overflow bit", A_STAT, 32'h0000_0002);
    chk_reg("R3", "level kept", A_FIFO, 32'h0000_0404);
    check("R5", "no pop while stopped", lg_cnt, 0);
    wr(A_CTRL, 32'h4);
    chk_reg("R2", "after clear", A_FIFO, 32'h0000_0002);
  endtask

  task automatic t_irq();
    check("R4", "irq masked", {31'd0, irq}, 32'd0);
    wr(A_EN, 32'hFFFF_FFFF);
    chk_reg("R4", "enable mask", A_EN, 32'h0002_28A6);
    check("R4", "irq enabled", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'h0000_0004);
    chk_reg("R4", "w1c other bit", A_STAT, 32'h0000_0002);
    wr(A_STAT, 32'h0000_0002);
    chk_reg("R4", "w1c clears", A_STAT, 32'h0);
    check("R4", "irq dropped", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_unknown();
    wr(A_CTRL, 32'h1);
    wr(A_PUSH, 32'h0000_0000);
    wr(A_PUSH, 32'h9000_0000);
    wr(A_PUSH, 32'h3000_0000);
    wr(A_PUSH, 32'hF000_0001);
    idle(4);
    chk_reg("R6", "unknown bit", A_STAT, 32'h0000_0004);
    check("R6", "nothing dispatched", lg_cnt, exp_n);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_crypt_empty();
    wr(A_PUSH, 32'h5000_0010);
    wr(A_PUSH, 32'h5800_0010);
    idle(4);
    chk_reg("R9", "empty slot bits", A_STAT, 32'h0002_0800);
    check("R9", "crypt discarded", lg_cnt, exp_n);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_setkey();
    wr(A_PUSH, 32'h1011_0000);
    for (int i = 0; i < 4; i++) wr(A_PUSH, 32'hA000_0000 + i);
    wr(A_PUSH, 32'h5000_0040);
    idle(6);
    check("R7", "count after 128 load", lg_cnt, exp_n + 2);
    chk_disp("R7", exp_n, 4'd1, 32'h1011_0000, 4'd4);
    check("R7", "arg0", arg_of(exp_n, 0), 32'hA000_0000);
    check("R7", "arg3", arg_of(exp_n, 3), 32'hA000_0003);
    check("R7", "arg4 zero", arg_of(exp_n, 4), 32'h0);
    chk_disp("R9", exp_n + 1, 4'd5, 32'h5000_0040, 4'd0);
    exp_n += 2;
    wr(A_PUSH, 32'h1882_0000);
    for (int i = 0; i < 8; i++) wr(A_PUSH, 32'hB000_0000 + i);
    idle(6);
    check("R7", "count after 256 load", lg_cnt, exp_n + 1);
    chk_disp("R7", exp_n, 4'd1, 32'h1882_0000, 4'd8);
    check("R7", "arg7", arg_of(exp_n, 7), 32'hB000_0007);
    exp_n += 1;
    wr(A_PUSH, 32'h1040_0000);
    for (int i = 0; i < 6; i++) wr(A_PUSH, 32'hC000_0000 + i);
    idle(6);
    chk_disp("R7", exp_n, 4'd1, 32'h1040_0000, 4'd6);
    check("R7", "arg5", arg_of(exp_n, 5), 32'hC000_0005);
    check("R7", "arg6 zero", arg_of(exp_n, 6), 32'h0);
    exp_n += 1;
    chk_reg("R7", "no status from good loads", A_STAT, 32'h0);
    wr(A_PUSH, 32'h18C0_0000);
    wr(A_PUSH, 32'h1003_0000);
    wr(A_PUSH, 32'h6000_0000);
    idle(6);
    chk_reg("R7", "invalid bits", A_STAT, 32'h0000_2080);
    check("R7", "only readback dispatched", lg_cnt, exp_n + 1);
    chk_disp("R7", exp_n, 4'd6, 32'h6000_0000, 4'd0);
    exp_n += 1;
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_iv();
    wr(A_PUSH, 32'h2800_0000);
    for (int i = 0; i < 4; i++) wr(A_PUSH, 32'hD000_0000 + i);
    wr(A_PUSH, 32'h6000_0000);
    idle(6);
    check("R8", "count", lg_cnt, exp_n + 2);
    chk_disp("R8", exp_n, 4'd2, 32'h2800_0000, 4'd4);
    check("R8", "iv arg0", arg_of(exp_n, 0), 32'hD000_0000);
    check("R8", "iv arg3", arg_of(exp_n, 3), 32'hD000_0003);
    chk_disp("R8", exp_n + 1, 4'd6, 32'h6000_0000, 4'd0);
    exp_n += 2;
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(A_CTRL, 32'h2);
    wr(A_PUSH, 32'h6000_0000);
    idle(5);
    check("R5", "stopped no dispatch", lg_cnt, exp_n);
    rd(A_FIFO, d);
    check("R5", "word waits", {24'd0, d[15:8]}, 32'd1);
    wr(A_CTRL, 32'h3);
    idle(5);
    check("R5", "stop wins over start", lg_cnt, exp_n);
    wr(A_CTRL, 32'h1);
    idle(5);
    check("R5", "resumed", lg_cnt, exp_n + 1);
    exp_n += 1;
  endtask

  task automatic t_backpressure();
    @(negedge clk) dsp_ready = 1'b0;
    wr(A_PUSH, 32'h6000_0000);
    idle(5);
    check("R10", "valid held", {31'd0, dsp_valid}, 32'd1);
    check("R10", "word held", dsp_word, 32'h6000_0000);
    check("R10", "op field", {28'd0, dsp_op}, 32'd6);
    check("R10", "no transfer", lg_cnt, exp_n);
    @(negedge clk) dsp_ready = 1'b1;
    idle(3);
    check("R10", "one transfer", lg_cnt, exp_n + 1);
    check("R10", "valid drops", {31'd0, dsp_valid}, 32'd0);
    exp_n += 1;
  endtask

  task automatic t_barrier();
    logic [31:0] d;
    @(negedge clk) dp_busy = 1'b1;
    wr(A_PUSH, 32'h8800_0000);
    wr(A_PUSH, 32'h6000_0000);
    idle(6);
    chk_reg("R11", "no flag while busy", A_STAT, 32'h0);
    check("R11", "later command blocked", lg_cnt, exp_n);
    rd(A_FIFO, d);
    check("R11", "follower queued", {24'd0, d[15:8]}, 32'd1);
    @(negedge clk) dp_busy = 1'b0;
    idle(5);
    chk_reg("R11", "flag set", A_STAT, 32'h0000_0020);
    check("R11", "irq on flag", {31'd0, irq}, 32'd1);
    check("R11", "follower sent", lg_cnt, exp_n + 1);
    chk_disp("R11", exp_n, 4'd6, 32'h6000_0000, 4'd0);
    exp_n += 1;
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_PUSH, 32'h8000_0000);
    idle(5);
    chk_reg("R11", "quiet barrier", A_STAT, 32'h0);
    check("R11", "barrier not dispatched", lg_cnt, exp_n);
  endtask

  task automatic t_engreset();
    wr(A_PUSH, 32'h0000_0000);
    idle(3);
    chk_reg("R12", "status before", A_STAT, 32'h0000_0004);
    wr(A_CTRL, 32'h2);
    wr(A_PUSH, 32'h6000_0000);
    wr(A_CTRL, 32'h8);
    chk_reg("R12", "fifo emptied", A_FIFO, 32'h0000_0002);
    chk_reg("R12", "status cleared", A_STAT, 32'h0);
    chk_reg("R12", "enable kept", A_EN, 32'h0002_28A6);
    wr(A_PUSH, 32'h5000_0000);
    idle(5);
    check("R12", "stopped after reset", lg_cnt, exp_n);
    wr(A_CTRL, 32'h1);
    idle(5);
    chk_reg("R12", "slot forgotten", A_STAT, 32'h0000_0800);
    check("R12", "crypt dropped", lg_cnt, exp_n);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_PUSH, 32'h1900_0000);
    wr(A_PUSH, 32'h5800_0100);
    idle(6);
    check("R7", "hw key count", lg_cnt, exp_n + 2);
    chk_disp("R7", exp_n, 4'd1, 32'h1900_0000, 4'd0);
    chk_disp("R9", exp_n + 1, 4'd5, 32'h5800_0100, 4'd0);
    exp_n += 2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_fifo();
    t_irq();
    t_unknown();
    t_crypt_empty();
    t_setkey();
    t_iv();
    t_stop();
    t_backpressure();
    t_barrier();
    t_engreset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule